// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block is a clocked state machine that sits between a host and a byte-wide asynchronous static RAM with 17 address lines. The host asks for one read or one write at a time through a valid strobe with a write flag, an address and write data. The controller then drives the RAM's two chip selects (one active-low, one active-high), its active-low output enable and its active-low write enable in a sequence that meets every timing minimum of the part. It returns a one-cycle ready pulse and, for reads, the data word. The RAM data pins are presented as separate output, output-enable and input vectors, so the pad that joins them lies outside the block.

All timing minima are parameters in picoseconds. The controller turns each one into a cycle count by ceiling division by the clock period parameter. Between accesses the RAM is left deselected. A host sleep request puts the RAM into held deselection so that its supply may be lowered for data retention. After that request is withdrawn, the controller waits one full read-cycle time before the next access may start.

The defaults assume a 20 ns clock. With them, the write strobe lasts 3 cycles, the bus is held off for 1 cycle, the write hold lasts 1 cycle, the read window lasts 3 cycles, the read float lasts 1 cycle, and the wake recovery lasts 3 cycles.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, and whenever no access is running, the controller holds chip select 1 high, chip select 2 low, output enable high and write enable high, with the data drive off and ready low. The two selects always change together, so chip select 1 equals the inverse of chip select 2.
- R2: A write asserts both selects and write enable low together, with output enable high, for WP cycles. WP is the largest of ceil(40 ns), ceil(45 ns), ceil(45 ns) and WHZ + ceil(25 ns), each in clock cycles, which is 3 at default. Write enable is never low while the part is deselected.
- R3: During a write, the data drive stays off for the first WHZ = max(1, ceil(20 ns)) cycles of the strobe, which is 1 at default. It is then on with the write data until the end of the cycle after write enable rises, and off after that. The drive is never on while output enable is low.
- R4: The address and write data are latched at the edge that accepts a request. They stay unchanged on the RAM pins for the whole access, even if the host inputs change.
- R5: A read asserts both selects and output enable low, with write enable high, for RD cycles. RD is the largest of ceil(55 ns), ceil(25 ns) and ceil(55 ns), which is 3 at default. The RAM data present in the last of these cycles is returned on the read data output. Output enable is never low while write enable is low.
- R6: Each access ends with ready high for exactly one cycle. Ready rises at the edge that comes RD + OHZ cycles after the accepting edge for a read, and WP + WHOLD cycles after it for a write. OHZ is max(1, ceil(20 ns)) and WHOLD is max(1, ceil(55 ns) − WP), both 1 at default. The RAM is deselected while ready is high.
- R7: A request is taken at any rising edge where the controller is idle, including the edge that ends the ready cycle. The selects become active at that same edge.
- R8: A request presented while an access is running is ignored. No second access and no second ready pulse follow from it.
- R9: A sleep request seen while idle takes priority over a pending request. It keeps the RAM deselected, and every request is ignored while it stays high, so a write presented then never reaches the RAM.
- R10: After the sleep request is withdrawn, the controller stays deselected for WAKE = ceil(55 ns) = 3 cycles before it becomes idle. A request held from the moment of release therefore starts its access at the (WAKE + 1)-th edge after the release is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request strobe, sampled while idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Host word address |
| reqWdata | input | 8 | Host write data |
| sleepReq | input | 1 | Hold RAM in retention standby while high |
| hostReady | output | 1 | One-cycle pulse at the end of each access |
| hostRdata | output | 8 | Data returned by the last read |
| ramAddr | output | 17 | RAM address pins |
| ramCs1N | output | 1 | RAM chip select 1, active low |
| ramCs2 | output | 1 | RAM chip select 2, active high |
| ramOeN | output | 1 | RAM output enable, active low |
| ramWeN | output | 1 | RAM write enable, active low |
| ramDout | output | 8 | Data toward the RAM pins |
| ramDoutEn | output | 1 | Drive enable for ramDout |
| ramDin | input | 8 | Data from the RAM pins |

## Verification
All RAM pins change at the edge where the state register moves. The bench drives each request just after a falling edge and counts falling edges from there. The selects are therefore first seen active at falling edge 1. Ready is expected at falling edge RD + OHZ + 1 for a read and WP + WHOLD + 1 for a write, and held reads and writes during sleep start at falling edge WAKE + 2 after release. The RAM model counts its own enabled cycles and returns a poison value until RD of them have passed. A read window that is one cycle too short therefore returns wrong data rather than a silently correct word. Every pin is compared on the falling edge, half a cycle away from the edge that changes it.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_RFLOAT,
    ST_WRITE,
    ST_WHOLD,
    ST_SLEEP,
    ST_WAKE
  } ctrlState_e;

  // Strobes from the controller to the datapath. The pin fields are
  // registered in the controller; load and capture act at the coming edge.
  typedef struct packed {
    logic selOn;
    logic readOn;
    logic writeOn;
    logic driveOn;
    logic load;
    logic capture;
  } ctrlStrobes_t;

  function automatic int ceilCycles(input int durPs, input int clkPs);
    return (durPs + clkPs - 1) / clkPs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
`timescale 1ns/1ps
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int WHZ_CYC   = 1,
  parameter int WP_CYC    = 3,
  parameter int WHOLD_CYC = 1,
  parameter int RD_CYC    = 3,
  parameter int OHZ_CYC   = 1,
  parameter int WAKE_CYC  = 3,
  parameter int CNT_W     = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic         sleepReq,
  output ctrlStrobes_t strobes,
  output logic         hostReady
);

  localparam logic [CNT_W-1:0] WP_LAST    = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] WHOLD_LAST = CNT_W'(WHOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] OHZ_LAST   = CNT_W'(OHZ_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST  = CNT_W'(WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] WHZ_COUNT  = CNT_W'(WHZ_CYC);

  ctrlState_e       stateQ, nextState;
  logic [CNT_W-1:0] cntQ, nextCnt;
  logic             loadNow, captureNow, doneNow;
  logic             selQ, readQ, writeQ, driveQ, readyQ;
  logic             selNext, readNext, writeNext, driveNext;

  // Next-state logic; cntQ counts cycles spent in the current state.
  always_comb begin
    nextState  = stateQ;
    nextCnt    = cntQ + 1'b1;
    loadNow    = 1'b0;
    captureNow = 1'b0;
    doneNow    = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        nextCnt = '0;
        if (sleepReq) begin
          nextState = ST_SLEEP;
        end else if (reqValid) begin
          loadNow   = 1'b1;
          nextState = reqWrite ? ST_WRITE : ST_READ;
        end
      end
      ST_READ: begin
        if (cntQ == RD_LAST) begin
          captureNow = 1'b1;
          nextState  = ST_RFLOAT;
          nextCnt    = '0;
        end
      end
      ST_RFLOAT: begin
        if (cntQ == OHZ_LAST) begin
          doneNow   = 1'b1;
          nextState = ST_IDLE;
          nextCnt   = '0;
        end
      end
      ST_WRITE: begin
        if (cntQ == WP_LAST) begin
          nextState = ST_WHOLD;
          nextCnt   = '0;
        end
      end
      ST_WHOLD: begin
        if (cntQ == WHOLD_LAST) begin
          doneNow   = 1'b1;
          nextState = ST_IDLE;
          nextCnt   = '0;
        end
      end
      ST_SLEEP: begin
        nextCnt = '0;
        if (!sleepReq) nextState = ST_WAKE;
      end
      ST_WAKE: begin
        if (cntQ == WAKE_LAST) begin
          nextState = ST_IDLE;
          nextCnt   = '0;
        end
      end
      default: begin
        nextState = ST_IDLE;
        nextCnt   = '0;
      end
    endcase
  end

  // Pin strobes are decoded from the next state and registered, so every
  // RAM control pin leaves a flop at the same edge as the state change.
  always_comb begin
    selNext   = (nextState == ST_READ) || (nextState == ST_WRITE);
    readNext  = (nextState == ST_READ);
    writeNext = (nextState == ST_WRITE);
    driveNext = ((nextState == ST_WRITE) && (nextCnt >= WHZ_COUNT)) ||
                ((nextState == ST_WHOLD) && (nextCnt == '0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      selQ   <= 1'b0;
      readQ  <= 1'b0;
      writeQ <= 1'b0;
      driveQ <= 1'b0;
      readyQ <= 1'b0;
    end else begin
      stateQ <= nextState;
      cntQ   <= nextCnt;
      selQ   <= selNext;
      readQ  <= readNext;
      writeQ <= writeNext;
      driveQ <= driveNext;
      readyQ <= doneNow;
    end
  end

  always_comb begin
    strobes.selOn   = selQ;
    strobes.readOn  = readQ;
    strobes.writeOn = writeQ;
    strobes.driveOn = driveQ;
    strobes.load    = loadNow;
    strobes.capture = captureNow;
  end

  assign hostReady = readyQ;

endmodule

// File: rtl/asram_datapath.sv
`timescale 1ns/1ps
module asram_datapath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] ramDin,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramDout,
  output logic              ramDoutEn,
  output logic              ramCs1N,
  output logic              ramCs2,
  output logic              ramOeN,
  output logic              ramWeN,
  output logic [DATA_W-1:0] hostRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  // Address and write data are frozen for the whole access.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strobes.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strobes.capture) begin
      rdataQ <= ramDin;
    end
  end

  assign ramAddr   = addrQ;
  assign ramDout   = wdataQ;
  assign ramDoutEn = strobes.driveOn;
  assign ramCs1N   = ~strobes.selOn;
  assign ramCs2    = strobes.selOn;
  assign ramOeN    = ~strobes.readOn;
  assign ramWeN    = ~strobes.writeOn;
  assign hostRdata = rdataQ;

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int CLK_PS       = 20000,
  parameter int T_WRPULSE_PS = 40000,
  parameter int T_SELWR_PS   = 45000,
  parameter int T_ADDRWR_PS  = 45000,
  parameter int T_DSETUP_PS  = 25000,
  parameter int T_WRCYC_PS   = 55000,
  parameter int T_WRFLOAT_PS = 20000,
  parameter int T_ACC_PS     = 55000,
  parameter int T_OEACC_PS   = 25000,
  parameter int T_RDCYC_PS   = 55000,
  parameter int T_OEFLOAT_PS = 20000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              sleepReq,
  output logic              hostReady,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramCs1N,
  output logic              ramCs2,
  output logic              ramOeN,
  output logic              ramWeN,
  output logic [DATA_W-1:0] ramDout,
  output logic              ramDoutEn,
  input  logic [DATA_W-1:0] ramDin
);

  // Cycle counts, each rounded up from the picosecond minimum.
  localparam int WHZ_CYC   = maxOf(1, ceilCycles(T_WRFLOAT_PS, CLK_PS));
  localparam int WP_CYC    = maxOf(
      maxOf(ceilCycles(T_WRPULSE_PS, CLK_PS), ceilCycles(T_SELWR_PS, CLK_PS)),
      maxOf(ceilCycles(T_ADDRWR_PS, CLK_PS), WHZ_CYC + ceilCycles(T_DSETUP_PS, CLK_PS)));
  localparam int WHOLD_CYC = maxOf(1, ceilCycles(T_WRCYC_PS, CLK_PS) - WP_CYC);
  localparam int RD_CYC    = maxOf(
      maxOf(ceilCycles(T_ACC_PS, CLK_PS), ceilCycles(T_OEACC_PS, CLK_PS)),
      maxOf(1, ceilCycles(T_RDCYC_PS, CLK_PS)));
  localparam int OHZ_CYC   = maxOf(1, ceilCycles(T_OEFLOAT_PS, CLK_PS));
  localparam int WAKE_CYC  = maxOf(1, ceilCycles(T_RDCYC_PS, CLK_PS));
  localparam int LONGEST   = maxOf(maxOf(maxOf(WP_CYC, WHOLD_CYC), maxOf(RD_CYC, OHZ_CYC)),
                                   WAKE_CYC);
  localparam int CNT_W     = $clog2(LONGEST + 1);

  ctrlStrobes_t strobes;

  asram_ctrl_fsm #(
    .WHZ_CYC  (WHZ_CYC),
    .WP_CYC   (WP_CYC),
    .WHOLD_CYC(WHOLD_CYC),
    .RD_CYC   (RD_CYC),
    .OHZ_CYC  (OHZ_CYC),
    .WAKE_CYC (WAKE_CYC),
    .CNT_W    (CNT_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .sleepReq (sleepReq),
    .strobes  (strobes),
    .hostReady(hostReady)
  );

  asram_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .ramDin   (ramDin),
    .ramAddr  (ramAddr),
    .ramDout  (ramDout),
    .ramDoutEn(ramDoutEn),
    .ramCs1N  (ramCs1N),
    .ramCs2   (ramCs2),
    .ramOeN   (ramOeN),
    .ramWeN   (ramWeN),
    .hostRdata(hostRdata)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              sleepReq,
  input logic              hostReady,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              ramCs1N,
  input logic              ramCs2,
  input logic              ramOeN,
  input logic              ramWeN,
  input logic              ramDoutEn
);

  a_r1_select_pair: assert property (@(posedge clk) disable iff (!rstN)
    ramCs1N == !ramCs2);

  a_r2_we_inside_select: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |-> !ramCs1N);

  a_r5_oe_excludes_we: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |-> ramOeN);

  a_r3_no_drive_on_read: assert property (@(posedge clk) disable iff (!rstN)
    !ramOeN |-> !ramDoutEn);

  a_r3_float_window: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ramWeN) |-> !ramDoutEn);

  a_r3_hold_drive: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWeN) |-> ramDoutEn);

  a_r3_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWeN) |=> !ramDoutEn);

  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!ramCs1N && $past(!ramCs1N)) |-> $stable(ramAddr));

  a_r6_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |=> !hostReady);

  a_r6_ready_deselected: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> ramCs1N);

  a_r9_sleep_blocks: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sleepReq) && $past(ramCs1N)) |-> ramCs1N);

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .sleepReq (sleepReq),
  .hostReady(hostReady),
  .ramAddr  (ramAddr),
  .ramCs1N  (ramCs1N),
  .ramCs2   (ramCs2),
  .ramOeN   (ramOeN),
  .ramWeN   (ramWeN),
  .ramDoutEn(ramDoutEn)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;

  // Expected cycle counts for a 20 ns clock, worked out from the requirements.
  function automatic int cdiv(input int ns);
    return (ns + 19) / 20;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WHZ   = mx(1, cdiv(20));
  localparam int WP    = mx(mx(cdiv(40), cdiv(45)), mx(cdiv(45), WHZ + cdiv(25)));
  localparam int WHOLD = mx(1, cdiv(55) - WP);
  localparam int RD    = mx(mx(cdiv(55), cdiv(25)), cdiv(55));
  localparam int OHZ   = mx(1, cdiv(20));
  localparam int WAKE  = cdiv(55);
  localparam int RLAT  = RD + OHZ + 1;   // falling edges from drive to ready
  localparam int WLAT  = WP + WHOLD + 1;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, sleepReq;
  logic [16:0] reqAddr;
  logic [7:0]  reqWdata;
  logic        hostReady;
  logic [7:0]  hostRdata;
  logic [16:0] ramAddr;
  logic        ramCs1N, ramCs2, ramOeN, ramWeN;
  logic [7:0]  ramDout;
  logic        ramDoutEn;
  logic [7:0]  ramDin;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  asram_ctrl dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .sleepReq (sleepReq),
    .hostReady(hostReady),
    .hostRdata(hostRdata),
    .ramAddr  (ramAddr),
    .ramCs1N  (ramCs1N),
    .ramCs2   (ramCs2),
    .ramOeN   (ramOeN),
    .ramWeN   (ramWeN),
    .ramDout  (ramDout),
    .ramDoutEn(ramDoutEn),
    .ramDin   (ramDin)
  );

  // RAM model: 256 words keyed by the low address byte. Read data is
  // poisoned until RD enabled cycles have passed; a write commits the
  // last driven byte when the strobe overlap ends.
  logic [7:0] modelMem [256];
  logic [7:0] expMem   [256];
  int         rdCnt = 0;
  int         contention = 0;
  logic [7:0] wrLatch = 8'h00;
  logic [7:0] wrAddr = 8'h00;
  logic       wrPending = 1'b0;

  wire readEn  = !ramCs1N && ramCs2 && !ramOeN && ramWeN;
  wire writeEn = !ramCs1N && ramCs2 && !ramWeN;
  assign ramDin = (readEn && rdCnt >= RD) ? modelMem[ramAddr[7:0]] : 8'hEE;

  always @(negedge clk) begin
    rdCnt <= readEn ? rdCnt + 1 : 0;
    if (readEn && ramDoutEn) contention <= contention + 1;
    if (writeEn) begin
      wrPending <= 1'b1;
      wrAddr    <= ramAddr[7:0];
      if (ramDoutEn) wrLatch <= ramDout;
    end else if (wrPending) begin
      modelMem[wrAddr] <= wrLatch;
      wrPending        <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [16:0] addrOf(input int i);
    return {9'(i * 37 + 1), 8'(i)};
  endfunction
  function automatic logic [7:0] dataOf(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic checkIdlePins(input string req);
    check(ramCs1N && !ramCs2 && ramOeN && ramWeN && !ramDoutEn && !hostReady, req,
          "idle pins {cs1n,cs2,oen,wen,drv,rdy}",
          int'({ramCs1N, ramCs2, ramOeN, ramWeN, ramDoutEn, hostReady}), 6'b101100);
  endtask

  // Called on a falling edge; returns on the falling edge where ready is seen.
  task automatic doWrite(input logic [16:0] a, input logic [7:0] d, input bit poke);
    int strobe = 0, early = 0, bad = 0, addrBad = 0, readyAt = 0;
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (n == 1) begin
        reqValid = 1'b0;
        check(!hostReady, "R6", "ready longer than one cycle", int'(hostReady), 0);
        check(!ramCs1N, "R7", "write select at first edge", int'(ramCs1N), 0);
      end
      if (poke && n == 2) begin
        reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a ^ 17'h1; reqWdata = ~d;
      end
      if (poke && n == 3) reqValid = 1'b0;
      if (!ramWeN) begin
        strobe++;
        if (ramCs1N || !ramCs2 || !ramOeN) bad++;
        if (strobe <= WHZ && ramDoutEn) early++;
        if (strobe > WHZ && (!ramDoutEn || ramDout != d)) bad++;
      end
      if (!ramCs1N && ramAddr != a) addrBad++;
      if (n == WP + 1)
        check(ramWeN && ramDoutEn && ramDout == d, "R3", "drive held after WE rise",
              int'(ramDoutEn), 1);
      if (hostReady) begin
        readyAt = n;
        check(!ramDoutEn, "R3", "bus released at ready", int'(ramDoutEn), 0);
        break;
      end
    end
    check(strobe == WP, "R2", "write strobe cycles", strobe, WP);
    check(bad == 0, "R2", "strobe pins or data wrong", bad, 0);
    check(early == 0, "R3", "drive inside float window", early, 0);
    check(addrBad == 0, "R4", "address moved during write", addrBad, 0);
    check(readyAt == WLAT, "R6", "write ready latency", readyAt, WLAT);
  endtask

  task automatic doRead(input logic [16:0] a, input logic [7:0] exp);
    int oeLen = 0, bad = 0, readyAt = 0;
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (n == 1) begin
        reqValid = 1'b0;
        check(!hostReady, "R6", "ready longer than one cycle", int'(hostReady), 0);
        check(!ramCs1N, "R7", "read select at first edge", int'(ramCs1N), 0);
      end
      if (!ramOeN) begin
        oeLen++;
        if (ramCs1N || !ramCs2 || !ramWeN || ramDoutEn || ramAddr != a) bad++;
      end
      if (hostReady) begin
        readyAt = n;
        check(hostRdata == exp, "R5", "read data", int'(hostRdata), int'(exp));
        break;
      end
    end
    check(oeLen == RD, "R5", "read window cycles", oeLen, RD);
    check(bad == 0, "R5", "read pins wrong", bad, 0);
    check(readyAt == RLAT, "R6", "read ready latency", readyAt, RLAT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int selAt;
    int readyAt;
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; sleepReq = 1'b0;
    reqAddr = '0; reqWdata = '0;
    repeat (3) @(negedge clk);
    checkIdlePins("R1");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkIdlePins("R1");

    // Sweep every model word, with a busy-time request injected once (R8).
    for (int i = 0; i < 256; i++) begin
      doWrite(addrOf(i), dataOf(i), i == 100);
      expMem[i] = dataOf(i);
      if (i == 100) begin
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          check(ramCs1N && !hostReady, "R8", "busy request started an access",
                int'(ramCs1N), 1);
        end
      end
    end
    for (int i = 255; i >= 0; i--) doRead(addrOf(i), expMem[i]);

    // Second pattern on even words, then read back everything.
    for (int i = 0; i < 256; i += 2) begin
      doWrite(addrOf(i), ~dataOf(i), 1'b0);
      expMem[i] = ~dataOf(i);
    end
    for (int i = 0; i < 256; i++) doRead(addrOf(i), expMem[i]);

    // R9: sleep wins over a pending write, which never reaches the RAM.
    sleepReq = 1'b1; reqValid = 1'b1; reqWrite = 1'b1;
    reqAddr = addrOf(5); reqWdata = 8'h5A;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      check(ramCs1N && ramWeN && !hostReady, "R9", "access during sleep",
            int'(ramCs1N), 1);
    end
    reqValid = 1'b0; sleepReq = 1'b0;
    repeat (WAKE + 2) @(negedge clk);
    checkIdlePins("R1");
    doRead(addrOf(5), expMem[5]);

    // R10: request held from the moment of release waits out recovery.
    @(negedge clk);
    sleepReq = 1'b1;
    repeat (3) @(negedge clk);
    sleepReq = 1'b0; reqValid = 1'b1; reqWrite = 1'b0; reqAddr = addrOf(9);
    selAt = 0;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (!ramCs1N) begin
        selAt = n;
        reqValid = 1'b0;
        break;
      end
    end
    check(selAt == WAKE + 2, "R10", "first select after wake", selAt, WAKE + 2);
    readyAt = 0;
    for (int n = 1; n <= 20; n++) begin
      if (hostReady) begin
        readyAt = n;
        break;
      end
      @(negedge clk);
    end
    check(readyAt != 0 && hostRdata == expMem[9], "R10", "read after wake",
          int'(hostRdata), int'(expMem[9]));

    check(contention == 0, "R3", "drive while RAM outputs on", contention, 0);
    @(negedge clk);
    checkIdlePins("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule